// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating dual-slope analog-to-digital converter. A single start pulse runs one conversion. The block first discharges the integrator, then connects the unknown input for a fixed time, then connects a reference of opposite polarity. It then counts clock cycles until the integrator output returns through zero. The analog integrator, the switches and the zero-crossing comparator sit outside the block. The block drives one control line for each switch and reads the comparator as an asynchronous bit.

With `RES_BITS = N`, the fixed period is T = 2^N cycles. The discharge period lasts T and the input period lasts T. The reference window allows up to 2T cycles, so a conversion is about 4T long. The comparator passes through a two-stage synchronizer. The block subtracts the two cycles of synchronizer delay from the count, so the result equals the number of reference cycles the integrator needed to reach zero. If the window runs out first, the result saturates and an overrange flag is raised. Each extra bit of resolution doubles the conversion time.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset all three switch controls are low and busy, done and overrange are 0. The result is 0.
- R2: A start pulse while idle is followed by one all-open cycle. After that, the discharge control is high for exactly 2^RES_BITS cycles, and it comes before the input and reference phases.
- R3: After the discharge phase and one all-open cycle, the input control is high for exactly 2^RES_BITS cycles.
- R4: After the input phase and one all-open cycle, the reference control is high until a crossing is detected, and never for more than 2^(RES_BITS+1) cycles.
- R5: At most one switch control is high in any cycle. Whenever the active switch changes, at least one cycle with all switches open lies between the two.
- R6: The comparator bit (1 = integrator above zero) is synchronized through two flops. A crossing is the first reference-phase cycle in which the synchronized bit is 0. The result is the reference-phase cycle index of that cycle minus 2, floored at 0. When the comparator first reads low after K clock edges with the reference connected, the result is K.
- R7: If no crossing is detected by the last cycle of the 2^(RES_BITS+1)-cycle window, the result is all ones (2^(RES_BITS+1)-1) and overrange is 1. A conversion that ends on a crossing clears overrange.
- R8: Done is high for exactly one cycle, the cycle after the last reference cycle. Result and overrange change only in that cycle and hold their values otherwise.
- R9: A start pulse while a conversion is running is ignored. It changes no phase length, produces no extra done pulse and starts no later conversion.
- R10: Busy is high from the cycle after an accepted start through the last reference cycle, and low from the done cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Asynchronous comparator bit, 1 while integrator output is above zero |
| sw_zero_o | output | 1 | Integrator discharge switch control |
| sw_sig_o | output | 1 | Unknown-input switch control |
| sw_ref_o | output | 1 | Reference switch control |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovr_o | output | 1 | Last conversion ran past the window |
| result_o | output | RES_BITS+1 | Last conversion count |

## Verification
The bench goes after the edges of the count. A zero input must give 0 and not wrap negative, which it would if the synchronizer delay were subtracted without a floor. The largest input that still crosses within the last window cycle must give 2T-3. One unit more must saturate with overrange set; an off-by-one window bound would lose the former or mislabel the latter. A start pulse during the input and reference phases must leave the timing alone, while a design that restarts would stretch phases or emit a second done. A missing all-open cycle between phases would be seen as a direct switch handover.

// File: rtl/ds_adc_pkg.sv
package ds_adc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_GAP_Z = 3'd1,
        PH_ZERO  = 3'd2,
        PH_GAP_I = 3'd3,
        PH_INTEG = 3'd4,
        PH_GAP_R = 3'd5,
        PH_DEINT = 3'd6
    } phase_e;

    typedef struct packed {
        logic az;   // integrator discharge
        logic sig;  // unknown input
        logic rfr;  // reference
    } sw_t;

    function automatic sw_t sw_decode(input phase_e p);
        sw_t s;
        s = '0;
        case (p)
            PH_ZERO:  s.az  = 1'b1;
            PH_INTEG: s.sig = 1'b1;
            PH_DEINT: s.rfr = 1'b1;
            default:  s = '0;
        endcase
        return s;
    endfunction

    function automatic logic phase_busy(input phase_e p);
        return p != PH_IDLE;
    endfunction

endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SW-2:0], d_i};
    end

    assign q_o = sh[SW-1];
endmodule

// File: rtl/ds_seq.sv
module ds_seq
    import ds_adc_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              low_i,
    output phase_e            phase_o,
    output logic [RES_BITS:0] cnt_o,
    output sw_t               sw_o,
    output logic              fin_o,
    output logic              ovr_hit_o
);
    localparam int CW = RES_BITS + 1;
    localparam int T  = 1 << RES_BITS;
    localparam logic [CW-1:0] T_LAST = CW'(T - 1);
    localparam logic [CW-1:0] W_LAST = CW'(2 * T - 1);

    phase_e        ph, ph_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          win_end;

    assign win_end = (cnt == W_LAST);

    always_comb begin
        ph_n  = ph;
        cnt_n = cnt;
        case (ph)
            PH_IDLE: begin
                if (start_i) ph_n = PH_GAP_Z;
                cnt_n = '0;
            end
            PH_GAP_Z: begin
                ph_n  = PH_ZERO;
                cnt_n = '0;
            end
            PH_ZERO: begin
                if (cnt == T_LAST) begin
                    ph_n  = PH_GAP_I;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            PH_GAP_I: begin
                ph_n  = PH_INTEG;
                cnt_n = '0;
            end
            PH_INTEG: begin
                if (cnt == T_LAST) begin
                    ph_n  = PH_GAP_R;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            PH_GAP_R: begin
                ph_n  = PH_DEINT;
                cnt_n = '0;
            end
            PH_DEINT: begin
                if (low_i || win_end) begin
                    ph_n  = PH_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                ph_n  = PH_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            ph  <= ph_n;
            cnt <= cnt_n;
        end
    end

    assign phase_o   = ph;
    assign cnt_o     = cnt;
    assign sw_o      = sw_decode(ph);
    assign fin_o     = (ph == PH_DEINT) && (low_i || win_end);
    assign ovr_hit_o = (ph == PH_DEINT) && !low_i && win_end;

    // run-length counters used only by the properties below
    logic [CW:0] z_run, s_run, r_run;
    logic [2:0]  sw_vec;
    assign sw_vec = sw_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            z_run <= '0;
            s_run <= '0;
            r_run <= '0;
        end else begin
            z_run <= sw_o.az  ? z_run + 1'b1 : '0;
            s_run <= sw_o.sig ? s_run + 1'b1 : '0;
            r_run <= sw_o.rfr ? r_run + 1'b1 : '0;
        end
    end

    p_zero_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_o.az) |-> z_run == (CW+1)'(T));

    p_sig_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_o.sig) |-> s_run == (CW+1)'(T));

    p_ref_window_r4: assert property (@(posedge clk) disable iff (rst)
        sw_o.rfr |-> r_run < (CW+1)'(2 * T));

    p_one_switch_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_vec));

    p_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sw_o.az) || $rose(sw_o.sig) || $rose(sw_o.rfr)) |-> $past(sw_vec) == 3'b000);
endmodule

// File: rtl/ds_capture.sv
module ds_capture #(
    parameter int RES_BITS = 8,
    parameter int LAT      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin_i,
    input  logic              ovr_hit_i,
    input  logic [RES_BITS:0] cnt_i,
    output logic [RES_BITS:0] result_o,
    output logic              done_o,
    output logic              ovr_o
);
    localparam int RW = RES_BITS + 1;
    localparam logic [RW-1:0] FULL  = '1;
    localparam logic [RW-1:0] LAT_V = RW'(LAT);

    logic [RW-1:0] value;

    always_comb begin
        if (ovr_hit_i)          value = FULL;
        else if (cnt_i < LAT_V) value = '0;
        else                    value = cnt_i - LAT_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            done_o   <= 1'b0;
            ovr_o    <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                result_o <= value;
                ovr_o    <= ovr_hit_i;
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));

    p_ovr_full_r7: assert property (@(posedge clk) disable iff (rst)
        ovr_o |-> result_o == FULL);
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
    import ds_adc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic              sw_zero_o,
    output logic              sw_sig_o,
    output logic              sw_ref_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ovr_o,
    output logic [RES_BITS:0] result_o
);
    logic              cmp_s;
    phase_e            phase;
    logic [RES_BITS:0] cnt;
    sw_t               sw;
    logic              fin, ovr_hit;

    ds_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_s)
    );

    ds_seq #(.RES_BITS(RES_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .low_i     (!cmp_s),
        .phase_o   (phase),
        .cnt_o     (cnt),
        .sw_o      (sw),
        .fin_o     (fin),
        .ovr_hit_o (ovr_hit)
    );

    ds_capture #(.RES_BITS(RES_BITS), .LAT(SYNC_STAGES)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .fin_i     (fin),
        .ovr_hit_i (ovr_hit),
        .cnt_i     (cnt),
        .result_o  (result_o),
        .done_o    (done_o),
        .ovr_o     (ovr_o)
    );

    assign sw_zero_o = sw.az;
    assign sw_sig_o  = sw.sig;
    assign sw_ref_o  = sw.rfr;
    assign busy_o    = phase_busy(phase);

    p_busy_done_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/sim_dual_slope_ctrl.sv
`timescale 1ns/1ps
module sim_dual_slope_ctrl;
    localparam int NB = 8;
    localparam int T  = 1 << NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cmp;
    logic          sw_zero, sw_sig, sw_ref, busy, done, ovr;
    logic [NB:0]   result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_slope_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .cmp_i     (cmp),
        .sw_zero_o (sw_zero),
        .sw_sig_o  (sw_sig),
        .sw_ref_o  (sw_ref),
        .busy_o    (busy),
        .done_o    (done),
        .ovr_o     (ovr),
        .result_o  (result)
    );

    // behavioural integrator: input adds vin per cycle, reference removes T per cycle
    int       vin = 0;
    int       integ = 0;
    logic [2:0] sw_s = 3'b000;

    always @(negedge clk) sw_s <= {sw_zero, sw_sig, sw_ref};

    always @(posedge clk) begin
        if (sw_s[2])      integ <= 0;
        else if (sw_s[1]) integ <= integ + vin;
        else if (sw_s[0]) integ <= integ - T;
    end

    assign cmp = (integ > 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int v, input int extra_at, input string name);
        int  zl = 0, il = 0, rl = 0, idx = 0;
        int  fz = -1, fi = -1, fr = -1;
        int  bad_sw = 0, bad_busy = 0, moved = 0;
        int  exp_res, exp_rl;
        bit  exp_ovr, seen = 0;
        logic [2:0]  cur, prev_on;
        logic [NB:0] prev_res;
        logic        prev_ovr;
        prev_res = result;
        prev_ovr = ovr;
        prev_on  = 3'b000;
        if (v >= 2 * T - 2) begin
            exp_ovr = 1; exp_res = 2 * T - 1; exp_rl = 2 * T;
        end else begin
            exp_ovr = 0; exp_res = v; exp_rl = (v == 0) ? 1 : v + 3;
        end
        vin = v;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, {"R10 busy after start ", name}, busy, 1);
        while (!seen && idx < 5 * T) begin
            cur = {sw_zero, sw_sig, sw_ref};
            if ($countones(cur) > 1) bad_sw++;
            if (cur != 3'b000 && prev_on != 3'b000 && cur != prev_on) bad_sw++;
            prev_on = cur;
            if (sw_zero) begin zl++; if (fz < 0) fz = idx; end
            if (sw_sig)  begin il++; if (fi < 0) fi = idx; end
            if (sw_ref)  begin rl++; if (fr < 0) fr = idx; end
            if (!done && (result != prev_res || ovr != prev_ovr)) moved++;
            if (done) begin
                seen = 1;
            end else begin
                if (!busy) bad_busy++;
                start = (idx == extra_at);
                @(negedge clk);
                start = 1'b0;
                idx++;
            end
        end
        chk(seen, {"R8 done reached ", name}, seen, 1);
        chk(zl == T && fz == 1 && fz < fi && fi < fr, {"R2 discharge length/order ", name}, zl, T);
        chk(il == T && fi == T + 2, {"R3 input length ", name}, il, T);
        chk(rl == exp_rl, {"R4 reference length ", name}, rl, exp_rl);
        chk(bad_sw == 0, {"R5 switch overlap or no gap ", name}, bad_sw, 0);
        chk(moved == 0, {"R8 result held during run ", name}, moved, 0);
        chk(bad_busy == 0 && busy == 1'b0, {"R10 busy span ", name}, bad_busy, 0);
        if (exp_ovr)
            chk(int'(result) == exp_res, {"R7 saturated result ", name}, int'(result), exp_res);
        else
            chk(int'(result) == exp_res, {"R6 result ", name}, int'(result), exp_res);
        chk(ovr == exp_ovr, {"R7 overrange flag ", name}, ovr, exp_ovr);
        @(negedge clk);
        chk(done == 1'b0, {"R8 done one cycle ", name}, done, 0);
        if (extra_at >= 0) begin
            int late = 0;
            for (int k = 0; k < 6; k++) begin
                if (busy || done || sw_zero) late++;
                @(negedge clk);
            end
            chk(late == 0, {"R9 start while busy ignored ", name}, late, 0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({sw_zero, sw_sig, sw_ref} == 3'b000, "R1 switches open", {sw_zero, sw_sig, sw_ref}, 0);
        chk(busy == 0 && done == 0 && ovr == 0, "R1 flags clear", {busy, done, ovr}, 0);
        chk(result == '0, "R1 result zero", result, 0);
    endtask

    task automatic t_zero_input();      run_conv(0, -1, "zero");         endtask
    task automatic t_one_unit();        run_conv(1, -1, "one");          endtask
    task automatic t_mid();             run_conv(100, -1, "mid");        endtask
    task automatic t_equal_ref();       run_conv(T, -1, "equal");        endtask
    task automatic t_last_in_range();   run_conv(2 * T - 3, -1, "top");  endtask
    task automatic t_first_over();      run_conv(2 * T - 2, -1, "edge"); endtask
    task automatic t_far_over();        run_conv(700, -1, "far");        endtask
    task automatic t_start_in_integ();  run_conv(50, 300, "busy-integ"); endtask
    task automatic t_start_in_deint();  run_conv(200, 600, "busy-ref");  endtask
    task automatic t_recover();         run_conv(37, -1, "recover");     endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_zero_input();
        t_one_unit();
        t_mid();
        t_equal_ref();
        t_last_in_range();
        t_first_over();
        t_far_over();
        t_recover();
        t_start_in_integ();
        t_start_in_deint();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule